// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is one input-capture channel that hangs off a free-running timer. A pin is brought into the clock domain and filtered so that only pulses longer than a programmable number of bus cycles count as level changes. The filtered level is then tested against a selected edge kind. On each accepted edge, the current timer value is latched into a capture register.

In queue mode, capture and holding registers form a two-deep queue. The first edge after arming fills only the capture register and stays silent. Each later edge pushes the older value into the holding register and raises the channel flag. Each register is emptied by reading it.

A no-overwrite option freezes a full pair until software has read it. The lock is released by the reads themselves, never by flag handling. Whatever order reads, flag clears and edges arrive in, the next accepted edge that finds a value still queued sets the flag again. The flag is cleared by a one-bit write and, when enabled, drives an interrupt request.

Top module: `icap_channel`

## Requirements
- R1: The stored edge code selects which filtered transitions are edges: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both.
- R2: A config strobe with a nonzero code marks both registers empty and drops any edge in that cycle. The flag and the register values are left unchanged.
- R3: In queue mode, an accepted edge that finds both registers empty loads the timer into the capture register. The flag is left unchanged.
- R4: In queue mode, an accepted edge that finds the capture register full does three things: it copies the capture value into the holding register, loads the timer into the capture register, and sets the flag.
- R5: With no-overwrite set, edges leave capture, holding and flag untouched while the pair is locked. In queue mode the pair is locked when both registers are full. In latch mode it is locked when the capture register is full.
- R6: A capture-register read empties that register and a holding-register read empties that one. A read in the same cycle as an edge takes effect before the edge. In queue mode, an accepted edge that finds either register full sets the flag.
- R7: A flag write with data bit 1 clears the flag on the next cycle, and data bit 0 has no effect. If an edge sets the flag in the same cycle, the set wins.
- R8: The pin passes through two flops. A change of the synchronised level becomes a filtered transition only after it has lasted delay+1 consecutive cycles. Shorter pulses produce nothing.
- R9: In latch mode (queue mode low), each accepted edge loads the timer into the capture register and sets the flag. The holding register is left unchanged.
- R10: The interrupt request equals the flag ANDed with the interrupt enable, with no added delay.
- R11: After reset, capture, holding and flag are zero, both registers are empty and the edge code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous capture pin |
| timer_i | input | TMR_W | Free-running timer value |
| cfg_wr_i | input | 1 | Strobe loading the edge code |
| edge_sel_i | input | 2 | Edge code written by the strobe |
| queue_mode_i | input | 1 | 1: two-deep queue, 0: latch mode |
| no_ovw_i | input | 1 | No-overwrite lock enable |
| delay_i | input | DLY_W | Filter window in bus cycles |
| cap_rd_i | input | 1 | Capture register read strobe |
| hold_rd_i | input | 1 | Holding register read strobe |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wbit_i | input | 1 | Flag write data; 1 clears |
| irq_en_i | input | 1 | Interrupt enable |
| cap_o | output | TMR_W | Capture register |
| hold_o | output | TMR_W | Holding register |
| flag_o | output | 1 | Channel flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The pin is driven with long pulses under each edge code, with pulses of exactly delay and delay+1 cycles, and with a zero delay. These separate the edge decode from the filter boundary. Queue, latch and no-overwrite runs interleave reads and flag writes between edges, in both read orders, with strobes held across edge cycles. These runs show whether a lock or a clear can leave the flag inhibited for good. A re-arming write shows the silent first edge a second time.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // Does a filtered transition count as an edge for this mode?
  function automatic logic edge_hit(edge_mode_e m, logic rise, logic fall);
    case (m)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_ANY:  return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  // Queue mode: an accepted edge flags unless it lands in an empty pair.
  function automatic logic queue_flags(logic cap_full, logic hold_full);
    return cap_full | hold_full;
  endfunction

  // Lock condition of the no-overwrite option.
  function automatic logic pair_locked(logic qmode, logic cap_full, logic hold_full);
    return qmode ? (cap_full & hold_full) : cap_full;
  endfunction
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_glitch_filter.sv
module icap_glitch_filter #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             rise_o,
  output logic             fall_o
);
  logic             lvl_q;
  logic [DLY_W-1:0] cnt_q;
  logic             differ, upd;

  assign differ = (s_i != lvl_q);
  assign upd    = differ && (cnt_q == delay_i);
  assign rise_o = upd & s_i;
  assign fall_o = upd & ~s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (upd) begin
      lvl_q <= s_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: the filtered level only moves to the value the input already held
  p_level_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(s_i) == lvl_q));
  // R8: while the window is still running, the level is held
  p_short_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (differ && (cnt_q < delay_i)) |=> (lvl_q == $past(lvl_q)));
endmodule

// File: rtl/icap_queue.sv
module icap_queue
  import icap_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             arm_i,
  input  logic [TMR_W-1:0] timer_i,
  input  logic             queue_mode_i,
  input  logic             no_ovw_i,
  input  logic             cap_rd_i,
  input  logic             hold_rd_i,
  input  logic             clr_i,
  output logic [TMR_W-1:0] cap_o,
  output logic [TMR_W-1:0] hold_o,
  output logic             flag_o
);
  logic [TMR_W-1:0] cap_q, hold_q;
  logic cap_full_q, hold_full_q, flag_q;
  logic cap_keep, hold_keep, locked, accept, shift, set_flag;

  assign cap_keep  = cap_full_q  & ~cap_rd_i;
  assign hold_keep = hold_full_q & ~hold_rd_i;
  assign locked    = no_ovw_i & pair_locked(queue_mode_i, cap_keep, hold_keep);
  assign accept    = ev_i & ~locked & ~arm_i;
  assign shift     = accept & queue_mode_i & cap_keep;
  assign set_flag  = accept & (queue_mode_i ? queue_flags(cap_keep, hold_keep) : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q       <= '0;
      hold_q      <= '0;
      cap_full_q  <= 1'b0;
      hold_full_q <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      if (arm_i) begin
        cap_full_q  <= 1'b0;
        hold_full_q <= 1'b0;
      end else begin
        cap_full_q  <= cap_keep | accept;
        hold_full_q <= hold_keep | shift;
      end
      if (accept) cap_q  <= timer_i;
      if (shift)  hold_q <= cap_q;
      if (set_flag)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign hold_o = hold_q;
  assign flag_o = flag_q;

  // R2: arming empties both registers
  p_arm_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (!cap_full_q && !hold_full_q));
  // R3: an edge into an empty pair in queue mode leaves a clear flag clear
  p_first_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && queue_mode_i && !cap_keep && !hold_keep && !flag_q) |=> !flag_q);
  // R4: a queued shift carries the old capture value and raises the flag
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> ((hold_q == $past(cap_q)) && flag_q && hold_full_q));
  // R5: a locked pair is not written by an edge
  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && locked) |=> ($stable(cap_q) && $stable(hold_q)));
  // R9: latch mode never touches the holding register
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_mode_i |=> $stable(hold_q));
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int TMR_W     = 16,
  parameter int DLY_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [TMR_W-1:0] timer_i,
  input  logic             cfg_wr_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             queue_mode_i,
  input  logic             no_ovw_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             cap_rd_i,
  input  logic             hold_rd_i,
  input  logic             flag_wr_i,
  input  logic             flag_wbit_i,
  input  logic             irq_en_i,
  output logic [TMR_W-1:0] cap_o,
  output logic [TMR_W-1:0] hold_o,
  output logic             flag_o,
  output logic             irq_o
);
  edge_mode_e mode_q;
  logic pin_s, rise_w, fall_w, ev_w, arm_w, clr_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        mode_q <= EDGE_OFF;
    else if (cfg_wr_i) mode_q <= edge_mode_e'(edge_sel_i);

  assign arm_w = cfg_wr_i && (edge_sel_i != 2'b00);
  assign ev_w  = edge_hit(mode_q, rise_w, fall_w);
  assign clr_w = flag_wr_i & flag_wbit_i;

  icap_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s));

  icap_glitch_filter #(.DLY_W(DLY_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .s_i(pin_s), .delay_i(delay_i),
    .rise_o(rise_w), .fall_o(fall_w));

  icap_queue #(.TMR_W(TMR_W)) u_q (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_w), .arm_i(arm_w), .timer_i(timer_i),
    .queue_mode_i(queue_mode_i), .no_ovw_i(no_ovw_i),
    .cap_rd_i(cap_rd_i), .hold_rd_i(hold_rd_i), .clr_i(clr_w),
    .cap_o(cap_o), .hold_o(hold_o), .flag_o(flag_o));

  assign irq_o = flag_o & irq_en_i;

  // R1: a disabled channel never changes its capture register
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == EDGE_OFF && !cfg_wr_i) |=> $stable(cap_o));
  // R7: a clear without a competing edge drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !ev_w) |=> !flag_o);
  // R10: the request never fires while disabled
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
endmodule

// File: tb/icap_channel_test.sv
module icap_channel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_i = 0, cfg_wr_i = 0, queue_mode_i = 0, no_ovw_i = 0;
  logic cap_rd_i = 0, hold_rd_i = 0, flag_wr_i = 0, flag_wbit_i = 0, irq_en_i = 0;
  logic [1:0]  edge_sel_i = 0;
  logic [7:0]  delay_i = 0;
  logic [15:0] timer_i = 0;
  logic [15:0] cap_o, hold_o;
  logic flag_o, irq_o;

  int vectors = 0, errors = 0, cycles = 0;
  bit checking = 0;
  string phase = "R11";

  always #2 clk = ~clk;   // 250 MHz

  icap_channel uut (.*);

  always @(negedge clk) timer_i <= timer_i + 16'd3;

  // behavioural reference
  int m_s1, m_s2, m_f, m_cnt, m_cfg;
  bit m_cf, m_hf, m_flag;
  int m_cap, m_hold;
  always @(posedge clk) begin
    bit upd, hit, ck, hk, setf, blocked;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_f = 0; m_cnt = 0; m_cfg = 0;
      m_cf = 0; m_hf = 0; m_flag = 0; m_cap = 0; m_hold = 0;
    end else begin
      upd = (m_s2 != m_f) && (m_cnt == int'(delay_i));
      hit = 0; setf = 0;
      if (upd && ((m_cfg == 1 && m_s2 == 1) || (m_cfg == 2 && m_s2 == 0) || m_cfg == 3)) hit = 1;
      if (m_s2 != m_f) begin
        if (upd) begin m_f = m_s2; m_cnt = 0; end else m_cnt++;
      end else m_cnt = 0;
      m_s2 = m_s1; m_s1 = int'(pin_i);
      ck = m_cf && !cap_rd_i;
      hk = m_hf && !hold_rd_i;
      if (cfg_wr_i && edge_sel_i != 0) begin m_cf = 0; m_hf = 0; hit = 0; end
      else begin m_cf = ck; m_hf = hk; end
      if (hit) begin
        blocked = no_ovw_i && (queue_mode_i ? (ck && hk) : ck);
        if (!blocked) begin
          if (queue_mode_i) begin
            if (ck) begin m_hold = m_cap; m_hf = 1; end
            if (ck || hk) setf = 1;
          end else setf = 1;
          m_cap = int'(timer_i); m_cf = 1;
        end
      end
      if (setf) m_flag = 1;
      else if (flag_wr_i && flag_wbit_i) m_flag = 0;
      if (cfg_wr_i) m_cfg = int'(edge_sel_i);
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) if (checking) begin
    #1;
    cmp("cap", int'(cap_o), m_cap);
    cmp("hold", int'(hold_o), m_hold);
    cmp("flag", int'(flag_o), int'(m_flag));
    cmp("irq", int'(irq_o), int'(m_flag & irq_en_i));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse(int hi, int lo);
    pin_i = 1; tick(hi); pin_i = 0; tick(lo);
  endtask
  task automatic arm(logic [1:0] code);
    edge_sel_i = code; cfg_wr_i = 1; tick(1); cfg_wr_i = 0;
  endtask
  task automatic rd(bit c, bit h);
    cap_rd_i = c; hold_rd_i = h; tick(1); cap_rd_i = 0; hold_rd_i = 0;
  endtask
  task automatic fwr(bit b);
    flag_wr_i = 1; flag_wbit_i = b; tick(1); flag_wr_i = 0; flag_wbit_i = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired in %s", phase);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    // R11: reset state
    cmp("reset cap", int'(cap_o), 0);
    cmp("reset hold", int'(hold_o), 0);
    cmp("reset flag", int'(flag_o), 0);
    rst_n = 1; tick(1); checking = 1;
    tick(2);
    queue_mode_i = 1; delay_i = 8'd2;
    phase = "R2";  arm(2'b01); tick(2);
    phase = "R3";  pulse(6, 8);          // silent first edge
    phase = "R4";  pulse(6, 8);          // shift + flag
    pulse(6, 8);
    phase = "R10"; irq_en_i = 1; tick(3); irq_en_i = 0; tick(2); irq_en_i = 1;
    phase = "R7";  fwr(0); tick(2); fwr(1); tick(2);
    phase = "R8";  pulse(2, 8); pulse(3, 8); pulse(1, 8);
    delay_i = 8'd0; pulse(1, 6); delay_i = 8'd5; pulse(5, 10); pulse(6, 12);
    delay_i = 8'd1;
    phase = "R1";  arm(2'b10); pulse(5, 6); pulse(5, 6);
    arm(2'b11); pulse(5, 6); pulse(5, 6);
    arm(2'b00); pulse(5, 6); pulse(5, 6);
    phase = "R2";  arm(2'b01); pulse(5, 6); fwr(1); pulse(5, 6);
    phase = "R5";  no_ovw_i = 1; fwr(1); pulse(5, 6); pulse(5, 6); pulse(5, 6);
    phase = "R6";  fwr(1); rd(1, 0); pulse(5, 6); rd(0, 1); pulse(5, 6);
    rd(0, 1); fwr(1); rd(1, 0); pulse(5, 6); pulse(5, 6);
    rd(1, 1); pulse(5, 6); pulse(5, 6); pulse(5, 6);
    cap_rd_i = 1; pulse(5, 6); cap_rd_i = 0; tick(2);
    hold_rd_i = 1; pulse(5, 6); pulse(5, 6); hold_rd_i = 0; tick(2);
    phase = "R7";  flag_wr_i = 1; flag_wbit_i = 1; rd(1, 1); pulse(5, 6);
    flag_wr_i = 0; flag_wbit_i = 0; tick(2);
    phase = "R9";  queue_mode_i = 0; no_ovw_i = 0; arm(2'b01);
    pulse(5, 6); pulse(5, 6); fwr(1);
    no_ovw_i = 1; pulse(5, 6); pulse(5, 6); rd(1, 0); pulse(5, 6);
    phase = "R5";  pulse(5, 6); no_ovw_i = 0; pulse(5, 6);
    tick(4);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule